// File: doc/BRIEF.md
# Four-Sample Rotating Average Filter

This block is a streaming low-pass filter for unsigned 8-bit samples. It reports the average of the four most recent samples. It does not shift a delay line. Instead it holds four sample slots and fills them in a fixed rotation, one slot per clock. A five-state controller drives one write enable for each slot. Each slot keeps its value until its turn comes round again, so the newest sample always replaces the oldest one.

Every clock the four slots feed a two-level adder tree that is 10 bits wide. The sum is divided by four with a right shift and the result is stored in the output register. Leaving reset always passes through a clear state, which empties all four slots and the output. While the window is filling, the missing samples therefore count as zero.

Top module: `quad_avg_filter`

## Requirements
- R1: A synchronous active-high `rst` clears all four slots and `avg_o` to 0. The first cycle after `rst` falls is a clear cycle in which the sample on `smp_i` is not captured and `avg_o` stays 0.
- R2: After the clear cycle exactly one slot is written per clock, in the fixed order A, B, C, D, then back to A. The order never skips, repeats or stops while `rst` is low.
- R3: The value on `smp_i` during a write cycle is stored at that clock edge in the slot being written, replacing the oldest of the four stored samples.
- R4: `avg_o` equals the sum of the four stored samples shifted right by two bits (the fraction is truncated). For example, 180+180+181+182 = 723 gives 180.
- R5: `avg_o` is registered. After the edge that writes sample n, the next edge makes `avg_o` show the average of the window that ends with sample n.
- R6: The internal sum cannot overflow: four samples of 255 give `avg_o` = 255.
- R7: While fewer than four samples have been written since the clear, the unwritten slots count as 0. For samples 180, 180, 180, 180 the outputs are 45, 90, 135 and 180.
- R8: A slot that is not being written keeps its stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 8 | Unsigned input sample, one per clock |
| avg_o | output | 8 | Registered average of the last four samples |

## Verification
The filter is first driven with the step-and-settle sequence from a fill of 180s (180, 181, 182, 190 and then a run of 182s). This is checked against hand-computed outputs, which confirms both the one-cycle output delay and that the window slides by exactly one sample per clock. Next come windows that start empty, from zeros to four 180s, which separate a correct clear from stale contents. Runs of 255s and a 0/255 alternation expose a sum that is too narrow or a wrong order of overwrite, and values such as 1, 1, 1, 0 expose rounding where truncation is required. A long pseudo-random stream is compared against a model of the last four samples. A reset in the middle of the stream, with a marker value held on the input during the clear cycle, shows that nothing is captured then and that the rotation starts again at the first slot.

// File: rtl/qaf_pkg.sv
package qaf_pkg;

    // Number of averaged samples; the divide is a shift, so this is a power of two
    localparam int TAPS  = 4;
    localparam int SHIFT = $clog2(TAPS);

    typedef enum logic [2:0] {
        ST_CLEAR = 3'd0,
        ST_WR_A  = 3'd1,
        ST_WR_B  = 3'd2,
        ST_WR_C  = 3'd3,
        ST_WR_D  = 3'd4
    } qaf_state_e;

    typedef struct packed {
        qaf_state_e st;
    } qaf_ctrl_s;

endpackage

// File: rtl/qaf_ctrl.sv
module qaf_ctrl
    import qaf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic            clr_o,
    output logic [TAPS-1:0] wr_en_o
);

    qaf_ctrl_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_CLEAR: nxt_d.st = ST_WR_A;
            ST_WR_A:  nxt_d.st = ST_WR_B;
            ST_WR_B:  nxt_d.st = ST_WR_C;
            ST_WR_C:  nxt_d.st = ST_WR_D;
            ST_WR_D:  nxt_d.st = ST_WR_A;
            default:  nxt_d.st = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '{st: ST_CLEAR};
        else     cur_q <= nxt_d;
    end

    // One write enable per slot, decoded from the state
    always_comb begin
        clr_o   = (cur_q.st == ST_CLEAR);
        wr_en_o = '0;
        unique case (cur_q.st)
            ST_WR_A: wr_en_o[0] = 1'b1;
            ST_WR_B: wr_en_o[1] = 1'b1;
            ST_WR_C: wr_en_o[2] = 1'b1;
            ST_WR_D: wr_en_o[3] = 1'b1;
            default: wr_en_o    = '0;
        endcase
    end

    // R2
    one_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en_o) && (clr_o || $countones(wr_en_o) == 1));

    // R2
    wrap_order_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o[TAPS-1] |=> wr_en_o[0]);

    // R1
    clear_first_chk: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> wr_en_o[0]);

endmodule

// File: rtl/qaf_bank.sv
module qaf_bank
    import qaf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic [TAPS-1:0]         wr_en_i,
    input  logic [DW-1:0]           smp_i,
    output logic [TAPS-1:0][DW-1:0] slot_o
);

    logic [TAPS-1:0][DW-1:0] slot_q, slot_d;

    for (genvar g = 0; g < TAPS; g++) begin : g_slot
        always_comb begin
            if (clr_i)           slot_d[g] = '0;
            else if (wr_en_i[g]) slot_d[g] = smp_i;
            else                 slot_d[g] = slot_q[g];
        end

        always_ff @(posedge clk) begin
            if (rst) slot_q[g] <= '0;
            else     slot_q[g] <= slot_d[g];
        end

        // R8
        hold_slot_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr_i && !wr_en_i[g]) |=> $stable(slot_q[g]));

        // R3
        capture_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr_i && wr_en_i[g]) |=> (slot_q[g] == $past(smp_i)));
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/qaf_sum.sv
module qaf_sum
    import qaf_pkg::*;
#(
    parameter int DW = 8,
    localparam int SW = DW + SHIFT
) (
    input  logic [TAPS-1:0][DW-1:0] slot_i,
    output logic [SW-1:0]           sum_o
);

    localparam int PAIRS = TAPS / 2;

    logic [PAIRS-1:0][DW:0] pair_s;

    // First level: add neighbouring slots
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_s[p] = {1'b0, slot_i[2*p]} + {1'b0, slot_i[2*p+1]};
    end

    // Second level: add the two pair sums
    assign sum_o = {1'b0, pair_s[0]} + {1'b0, pair_s[1]};

endmodule

// File: rtl/quad_avg_filter.sv
module quad_avg_filter
    import qaf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] smp_i,
    output logic [DW-1:0] avg_o
);

    localparam int SW = DW + SHIFT;

    logic                    clr;
    logic [TAPS-1:0]         wr_en;
    logic [TAPS-1:0][DW-1:0] slot;
    logic [SW-1:0]           sum;
    logic [DW-1:0]           avg_q, avg_d;

    qaf_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .clr_o   (clr),
        .wr_en_o (wr_en)
    );

    qaf_bank #(.DW(DW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr),
        .wr_en_i (wr_en),
        .smp_i   (smp_i),
        .slot_o  (slot)
    );

    qaf_sum #(.DW(DW)) u_sum (
        .slot_i (slot),
        .sum_o  (sum)
    );

    always_comb begin
        if (clr) avg_d = '0;
        else     avg_d = sum[SW-1:SHIFT];
    end

    always_ff @(posedge clk) begin
        if (rst) avg_q <= '0;
        else     avg_q <= avg_d;
    end

    assign avg_o = avg_q;

    // Largest stored sample, used only by the bound check below
    logic [DW-1:0] slot_max;
    always_comb begin
        slot_max = '0;
        for (int k = 0; k < TAPS; k++)
            if (slot[k] > slot_max) slot_max = slot[k];
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (avg_o <= $past(slot_max)));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (avg_o == '0));

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (avg_o == '0));

endmodule

// File: tb/sim_quad_avg_filter.sv
`timescale 1ns/1ps
module sim_quad_avg_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] smp = 8'd0;
    logic [7:0] avg;

    always #2.5 clk = ~clk;

    quad_avg_filter #(.DW(8)) u0 (
        .clk   (clk),
        .rst   (rst),
        .smp_i (smp),
        .avg_o (avg)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Model of the last four samples since the clear, and the next slot to write
    logic [7:0] win [4];
    int         wp;

    // {sample, hand-computed average of the window ending with it}
    localparam int NV = 14;
    localparam logic [15:0] VEC [NV] = '{
        {8'd180, 8'd45 }, {8'd180, 8'd90 }, {8'd180, 8'd135}, {8'd180, 8'd180},
        {8'd180, 8'd180}, {8'd181, 8'd180}, {8'd182, 8'd180}, {8'd190, 8'd183},
        {8'd182, 8'd183}, {8'd182, 8'd184}, {8'd182, 8'd184}, {8'd182, 8'd182},
        {8'd182, 8'd182}, {8'd182, 8'd182}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_avg();
        int s = 0;
        for (int k = 0; k < 4; k++) s += int'(win[k]);
        return 8'(s >> 2);
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 4; k++) win[k] = 8'd0;
        wp = 0;
    endtask

    // Drive a sample, let it be written, then check the window before it (R5)
    task automatic step(input logic [7:0] s, input string req);
        smp = s;
        @(posedge clk);
        @(negedge clk);
        check(req, avg, model_avg());
        win[wp] = s;
        wp = (wp + 1) % 4;
    endtask

    task automatic do_reset(input logic [7:0] marker);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", avg, 8'd0);
        rst = 1'b0;
        smp = marker;          // held during the clear cycle, must not be captured
        @(posedge clk);
        @(negedge clk);
        check("R1 clear", avg, 8'd0);
        model_clear();
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        model_clear();
        do_reset(8'd99);

        // Table walk: fill from zero (R7), then the step-and-settle sequence (R4, R5)
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][15:8], "R3 R5 model");
            if (k > 0) check("R4 R7 table", avg, VEC[k-1][7:0]);
        end
        step(8'd182, "R4 model");
        check("R4 table", avg, VEC[NV-1][7:0]);

        // Largest inputs: no overflow (R6)
        for (int k = 0; k < 5; k++) step(8'd255, "R6 full scale");
        check("R6 max", avg, 8'd255);

        // Alternation: the slot overwritten must be the oldest (R2 R3)
        for (int k = 0; k < 8; k++) step((k % 2 == 0) ? 8'd0 : 8'd255, "R2 alternate");
        step(8'd0, "R2 alternate");
        check("R4 alternate", avg, 8'd127);

        // Truncation (R4): 1+1+1+0 = 3 -> 0
        step(8'd1, "R4 trunc"); step(8'd1, "R4 trunc");
        step(8'd1, "R4 trunc"); step(8'd0, "R4 trunc");
        step(8'd0, "R4 trunc");
        check("R4 truncate", avg, 8'd0);

        // Pseudo-random stream against the model (R2 R8)
        lfsr = 8'hA5;
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr, "R8 random");
        end

        // Reset in mid-stream: clear restarts rotation at slot A (R1 R7)
        do_reset(8'd250);
        step(8'd200, "R1 restart");
        step(8'd0,   "R7 restart");
        check("R7 single", avg, 8'd50);
        step(8'd0, "R7 restart");
        step(8'd0, "R7 restart");
        step(8'd40, "R2 wrap");
        step(8'd0, "R2 wrap");
        check("R2 wrap", avg, 8'd10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule